// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Sequencer

This block sits between a synchronous host port and an asynchronous extended-data-out DRAM that has 4-bit data and a multiplexed address bus. The host raises a request that carries a 24-bit word address, a write flag and a write nibble. It holds the request until a single-cycle acknowledge comes back. For reads, a read-valid pulse arrives together with the acknowledge and brings the captured nibble. On the memory side, the block drives active-low row strobe, column strobe, write enable and output enable. It also drives a 12-bit address bus and a data bus, split into an output value, an output enable and an input value.

Every timing limit is given in picoseconds and converted to a whole number of clocks by rounding up against the clock-period parameter. With the defaults (10 ns clock) the counts are:

| Limit | Clocks |
|-------|--------|
| minimum row-active time | 5 |
| row precharge | 3 |
| column precharge | 1 |
| row-to-column delay | 2 |
| access from row strobe | 5 |
| access from column strobe | 2 |
| access from column address | 3 |
| write strobe width | 1 |

After an access the row stays open. A later request to the same row is served as a column-only cycle. A request to another row first closes the open row and precharges, then opens the new row. A refresh grant closes the open row and keeps the block idle.

Top module: `edo_seq`

## Requirements
- R1: The row, `req_addr[23:12]`, is on `dram_addr` when `dram_ras_n` falls and stays there while it is low before the column phase. The column, `req_addr[11:0]`, is on `dram_addr` one clock before `dram_cas_n` falls and stays there until the next column or row is loaded.
- R2: For a read, `dram_we_n` stays high and `dram_oe_n` falls together with `dram_cas_n`. `ack` and `rd_valid` pulse high for one clock, and `rd_data` carries the nibble stored at that address. `rd_valid` is never high without `ack`.
- R3: For a write, `dram_we_n` is low and `dram_dq_oe` drives `req_wdata` from one clock before `dram_cas_n` falls until `dram_cas_n` rises. `ack` pulses and `rd_valid` stays low.
- R4: `dram_ras_n` stays low for at least 5 clocks each time it falls.
- R5: `dram_ras_n` stays high for at least 3 clocks between low periods. `dram_cas_n` stays high for at least 1 clock between low pulses.
- R6: Read data is captured no earlier than 5 clocks after `dram_ras_n` fell, 2 clocks after `dram_cas_n` fell, and 3 clocks after the column address appeared.
- R7: While a row is open, a request to the same row produces no new fall of `dram_ras_n`.
- R8: A request to a different row raises `dram_ras_n` and precharges, then opens the new row with exactly one new fall of `dram_ras_n`.
- R9: While `ref_grant` is high, an open row is closed once R4 allows it. Both strobes then stay high and no pending request is acknowledged. The request is served after the grant drops.
- R10: `dram_dq_oe` is never high while `dram_oe_n` is low, and it is low in the clock before `dram_oe_n` falls.
- R11: During reset, all four strobes are high and `dram_dq_oe`, `ack` and `rd_valid` are low.
- R12: `dram_cas_n` is low only while `dram_ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req | input | 1 | access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | word address, row in upper 12 bits |
| req_wdata | input | 4 | write nibble |
| ref_grant | input | 1 | close the row and stay idle while high |
| ack | output | 1 | one-clock completion pulse |
| rd_valid | output | 1 | read data valid, with ack |
| rd_data | output | 4 | captured read nibble |
| dram_ras_n | output | 1 | row strobe, active low |
| dram_cas_n | output | 1 | column strobe, active low |
| dram_we_n | output | 1 | write enable, active low |
| dram_oe_n | output | 1 | output enable, active low |
| dram_addr | output | 12 | multiplexed row/column address |
| dram_dq_out | output | 4 | data driven toward the memory |
| dram_dq_oe | output | 1 | drive enable for dram_dq_out |
| dram_dq_in | input | 4 | data returned by the memory |

## Verification
The bench's memory model returns inverted data until its own access counters say the limits are met. A sequencer that samples a clock early therefore returns a wrong nibble instead of passing unnoticed. Row and precharge windows are timed with cycle counters on each strobe edge. A shortened row-active or precharge count shows up as a strobe edge arriving too soon.

Bursts to one row check that there is no extra row-strobe fall. A row change must give exactly one. A design that reopened rows on every hit, or that kept the wrong row, breaks those counts or returns another row's data. A refresh grant raised with a request pending must hold off the acknowledge. The same check catches a design that leaves the row open or keeps serving the request.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

   typedef enum logic [2:0] {
      ST_PRE   = 3'd0,
      ST_IDLE  = 3'd1,
      ST_RSET  = 3'd2,
      ST_RAS   = 3'd3,
      ST_COL   = 3'd4,
      ST_CAS   = 3'd5,
      ST_CASHI = 3'd6,
      ST_OPEN  = 3'd7
   } edo_state_e;

   // whole clocks covering a time in ps, never below one
   function automatic int unsigned clk_count(input int unsigned t_ps, input int unsigned clk_ps);
      int unsigned n;
      n = (t_ps + clk_ps - 1) / clk_ps;
      return (n < 1) ? 1 : n;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_age_ctr.sv
module edo_age_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] age
);
   // clocks since the last clear, saturating at all ones
   always_ff @(posedge clk) begin
      if (!rst_n)         age <= '0;
      else if (clr)       age <= '0;
      else if (age != '1) age <= age + 1'b1;
   end
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
   parameter int ROW_W = 12,
   parameter int COL_W = 12,
   parameter int PIN_W = 12
) (
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   input  logic             sel_col,
   output logic [PIN_W-1:0] pins
);
   logic [PIN_W-1:0] row_p, col_p;

   if (ROW_W == PIN_W) begin : g_row_full
      assign row_p = row;
   end else begin : g_row_pad
      assign row_p = {{(PIN_W-ROW_W){1'b0}}, row};
   end

   if (COL_W == PIN_W) begin : g_col_full
      assign col_p = col;
   end else begin : g_col_pad
      assign col_p = {{(PIN_W-COL_W){1'b0}}, col};
   end

   assign pins = sel_col ? col_p : row_p;
endmodule

// File: rtl/edo_seq.sv
module edo_seq
   import edo_seq_pkg::*;
#(
   parameter int unsigned CLK_PS    = 10000,
   parameter int          ROW_W     = 12,
   parameter int          COL_W     = 12,
   parameter int          PIN_W     = 12,
   parameter int          DQ_W      = 4,
   parameter int unsigned T_RAS_PS  = 50000,
   parameter int unsigned T_RP_PS   = 30000,
   parameter int unsigned T_CP_PS   = 10000,
   parameter int unsigned T_RCD_PS  = 15000,
   parameter int unsigned T_RAC_PS  = 50000,
   parameter int unsigned T_CAC_PS  = 13000,
   parameter int unsigned T_AA_PS   = 25000,
   parameter int unsigned T_WP_PS   = 10000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req,
   input  logic                   req_we,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   input  logic [DQ_W-1:0]        req_wdata,
   input  logic                   ref_grant,
   output logic                   ack,
   output logic                   rd_valid,
   output logic [DQ_W-1:0]        rd_data,
   output logic                   dram_ras_n,
   output logic                   dram_cas_n,
   output logic                   dram_we_n,
   output logic                   dram_oe_n,
   output logic [PIN_W-1:0]       dram_addr,
   output logic [DQ_W-1:0]        dram_dq_out,
   output logic                   dram_dq_oe,
   input  logic [DQ_W-1:0]        dram_dq_in
);
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int unsigned N_RAS = clk_count(T_RAS_PS, CLK_PS);
   localparam int unsigned N_RP  = clk_count(T_RP_PS,  CLK_PS);
   localparam int unsigned N_CP  = clk_count(T_CP_PS,  CLK_PS);
   localparam int unsigned N_RCD = clk_count(T_RCD_PS, CLK_PS);
   localparam int unsigned N_RAC = clk_count(T_RAC_PS, CLK_PS);
   localparam int unsigned N_CAC = clk_count(T_CAC_PS, CLK_PS);
   localparam int unsigned N_AA  = clk_count(T_AA_PS,  CLK_PS);
   localparam int unsigned N_WP  = clk_count(T_WP_PS,  CLK_PS);
   localparam int unsigned N_MAX = max2(max2(max2(N_RAS, N_RP), max2(N_CP, N_RCD)),
                                        max2(max2(N_RAC, N_CAC), max2(N_AA, N_WP)));
   localparam int AGE_W = $clog2(N_MAX + 1) + 1;
   localparam int N_AGE = 4;
   localparam int A_ST  = 0;
   localparam int A_RAS = 1;
   localparam int A_COL = 2;
   localparam int A_CAS = 3;
   localparam logic [AGE_W:0] K_RAS = (AGE_W+1)'(N_RAS);
   localparam logic [AGE_W:0] K_RP  = (AGE_W+1)'(N_RP);
   localparam logic [AGE_W:0] K_CP  = (AGE_W+1)'(N_CP);
   localparam logic [AGE_W:0] K_RCD = (AGE_W+1)'(N_RCD);
   localparam logic [AGE_W:0] K_RAC = (AGE_W+1)'(N_RAC);
   localparam logic [AGE_W:0] K_CAC = (AGE_W+1)'(N_CAC);
   localparam logic [AGE_W:0] K_AA  = (AGE_W+1)'(N_AA);
   localparam logic [AGE_W:0] K_WP  = (AGE_W+1)'(N_WP);

   // elaboration-time parameter checks
   if (ROW_W > PIN_W || COL_W > PIN_W) begin : g_bad_pins
      $error("edo_seq: address pins narrower than row or column field");
   end
   if (DQ_W < 1) begin : g_bad_dq
      $error("edo_seq: data width must be at least one");
   end

   edo_state_e state, nxt;
   logic [ROW_W-1:0] open_row;
   logic [COL_W-1:0] cur_col;
   logic             cur_we;
   logic [ROW_W-1:0] req_row;
   logic [COL_W-1:0] req_col;
   logic [COL_W-1:0] col_src;
   logic [PIN_W-1:0] pin_d;
   logic             latch_new, we_nxt, addr_load, done;
   logic [N_AGE-1:0] age_clr;
   logic [AGE_W-1:0] age_v [N_AGE];
   logic [AGE_W:0]   age_el [N_AGE];

   assign req_row = req_addr[ADDR_W-1 -: ROW_W];
   assign req_col = req_addr[COL_W-1:0];

   // elapsed clocks at the coming edge, one counter per timed event
   for (genvar i = 0; i < N_AGE; i++) begin : g_age
      edo_age_ctr #(.W(AGE_W)) u_age (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (age_clr[i]),
         .age   (age_v[i])
      );
      assign age_el[i] = {1'b0, age_v[i]} + 1'b1;
   end

   assign done = cur_we ? (age_el[A_CAS] >= K_WP)
                        : ((age_el[A_CAS] >= K_CAC) && (age_el[A_RAS] >= K_RAC) &&
                           (age_el[A_COL] >= K_AA));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_PRE:   if (age_el[A_ST] >= K_RP)  nxt = ST_IDLE;
         ST_IDLE:  if (req && !ref_grant)     nxt = ST_RSET;
         ST_RSET:                             nxt = ST_RAS;
         ST_RAS:   if (age_el[A_ST] >= K_RCD) nxt = ST_COL;
         ST_COL:                              nxt = ST_CAS;
         ST_CAS:   if (done)                  nxt = ST_CASHI;
         ST_CASHI: if (age_el[A_ST] >= K_CP)  nxt = ST_OPEN;
         ST_OPEN: begin
            if (ref_grant || (req && (req_row != open_row))) begin
               if (age_el[A_RAS] >= K_RAS) nxt = ST_PRE;
            end else if (req) begin
               nxt = ST_COL;
            end
         end
         default: nxt = ST_PRE;
      endcase
   end

   assign latch_new = ((state == ST_IDLE) && (nxt == ST_RSET)) ||
                      ((state == ST_OPEN) && (nxt == ST_COL));
   assign we_nxt    = latch_new ? req_we : cur_we;
   assign addr_load = ((state == ST_IDLE) && (nxt == ST_RSET)) ||
                      ((nxt == ST_COL) && (state != ST_COL));
   assign col_src   = (state == ST_OPEN) ? req_col : cur_col;

   assign age_clr[A_ST]  = (nxt != state);
   assign age_clr[A_RAS] = (nxt == ST_RAS) && (state != ST_RAS);
   assign age_clr[A_COL] = (nxt == ST_COL) && (state != ST_COL);
   assign age_clr[A_CAS] = (nxt == ST_CAS) && (state != ST_CAS);

   edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_mux (
      .row     (req_row),
      .col     (col_src),
      .sel_col (nxt == ST_COL),
      .pins    (pin_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_PRE;
         open_row    <= '0;
         cur_col     <= '0;
         cur_we      <= 1'b0;
         ack         <= 1'b0;
         rd_valid    <= 1'b0;
         rd_data     <= '0;
         dram_ras_n  <= 1'b1;
         dram_cas_n  <= 1'b1;
         dram_we_n   <= 1'b1;
         dram_oe_n   <= 1'b1;
         dram_addr   <= '0;
         dram_dq_out <= '0;
         dram_dq_oe  <= 1'b0;
      end else begin
         state <= nxt;
         if ((state == ST_IDLE) && (nxt == ST_RSET)) begin
            open_row <= req_row;
            cur_col  <= req_col;
         end
         if ((state == ST_OPEN) && (nxt == ST_COL)) cur_col <= req_col;
         if (latch_new) begin
            cur_we      <= req_we;
            dram_dq_out <= req_wdata;
         end
         if (addr_load) dram_addr <= pin_d;
         dram_ras_n <= (nxt == ST_PRE) || (nxt == ST_IDLE) || (nxt == ST_RSET);
         dram_cas_n <= (nxt != ST_CAS);
         dram_oe_n  <= !((nxt == ST_CAS) && !we_nxt);
         dram_we_n  <= !(((nxt == ST_COL) || (nxt == ST_CAS)) && we_nxt);
         dram_dq_oe <= ((nxt == ST_COL) || (nxt == ST_CAS)) && we_nxt;
         ack        <= (state == ST_CAS) && (nxt == ST_CASHI);
         rd_valid   <= (state == ST_CAS) && (nxt == ST_CASHI) && !cur_we;
         if ((state == ST_CAS) && (nxt == ST_CASHI) && !cur_we) rd_data <= dram_dq_in;
      end
   end
endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk
   import edo_seq_pkg::*;
#(
   parameter int unsigned CLK_PS   = 10000,
   parameter int unsigned T_RAS_PS = 50000,
   parameter int unsigned T_RP_PS  = 30000,
   parameter int unsigned T_CP_PS  = 10000,
   parameter int unsigned T_RAC_PS = 50000,
   parameter int unsigned T_CAC_PS = 13000,
   parameter int          DQ_W     = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ras_n,
   input logic            cas_n,
   input logic            we_n,
   input logic            oe_n,
   input logic            dq_oe,
   input logic [DQ_W-1:0] dq_out,
   input logic            ack,
   input logic            rd_valid
);
   localparam logic [15:0] C_RAS = 16'(clk_count(T_RAS_PS, CLK_PS));
   localparam logic [15:0] C_RP  = 16'(clk_count(T_RP_PS,  CLK_PS));
   localparam logic [15:0] C_CP  = 16'(clk_count(T_CP_PS,  CLK_PS));
   localparam logic [15:0] C_RAC = 16'(clk_count(T_RAC_PS, CLK_PS));
   localparam logic [15:0] C_CAC = 16'(clk_count(T_CAC_PS, CLK_PS));

   logic [15:0] ras_lo, ras_hi, cas_lo, cas_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_lo <= '0; ras_hi <= '0; cas_lo <= '0; cas_hi <= '0;
      end else begin
         ras_lo <= ras_n ? 16'd0 : ((ras_lo == 16'hFFFF) ? ras_lo : ras_lo + 16'd1);
         ras_hi <= !ras_n ? 16'd0 : ((ras_hi == 16'hFFFF) ? ras_hi : ras_hi + 16'd1);
         cas_lo <= cas_n ? 16'd0 : ((cas_lo == 16'hFFFF) ? cas_lo : cas_lo + 16'd1);
         cas_hi <= !cas_n ? 16'd0 : ((cas_hi == 16'hFFFF) ? cas_hi : cas_hi + 16'd1);
      end
   end

   p_ras_active_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (ras_lo >= C_RAS));
   p_ras_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (ras_hi >= C_RP));
   p_cas_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> (cas_hi >= C_CP));
   p_capture_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ((ras_lo >= C_RAC) && (cas_lo >= C_CAC)));
   p_write_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !we_n) |-> ($past(dq_oe) && $past(!we_n) && $stable(dq_out)));
   p_we_oe_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> we_n);
   p_valid_with_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ack);
   p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   p_no_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n);
   p_release_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n) |-> !$past(dq_oe));
   p_cas_in_ras_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);
endmodule

bind edo_seq edo_seq_chk #(
   .CLK_PS(CLK_PS), .T_RAS_PS(T_RAS_PS), .T_RP_PS(T_RP_PS), .T_CP_PS(T_CP_PS),
   .T_RAC_PS(T_RAC_PS), .T_CAC_PS(T_CAC_PS), .DQ_W(DQ_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
   .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .dq_out(dram_dq_out),
   .ack(ack), .rd_valid(rd_valid)
);

// File: tb/tb_edo_seq.sv
module tb_edo_seq;
   localparam int N_RAS = 5;
   localparam int N_RP  = 3;
   localparam int N_CP  = 1;
   localparam int N_RAC = 5;
   localparam int N_CAC = 2;
   localparam int N_AA  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, req_we = 1'b0, ref_grant = 1'b0;
   logic [23:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic        ack, rd_valid;
   logic [3:0]  rd_data;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [11:0] dram_addr;
   logic [3:0]  dram_dq_out;
   logic [3:0]  dram_dq_in = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   edo_seq dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .ref_grant(ref_grant), .ack(ack), .rd_valid(rd_valid),
      .rd_data(rd_data), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
      .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   always #5 clk = ~clk;

   task automatic check(input bit cond, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [3:0] init_val(input logic [23:0] a);
      return a[3:0] ^ a[15:12] ^ a[23:20] ^ a[9:6];
   endfunction

   // memory model keyed by pins, reference keyed by host address
   logic [3:0] mdl  [logic [23:0]];
   logic [3:0] refm [logic [23:0]];

   function automatic logic [3:0] mdl_rd(input logic [23:0] k);
      return mdl.exists(k) ? mdl[k] : init_val(k);
   endfunction
   function automatic logic [3:0] ref_rd(input logic [23:0] k);
      return refm.exists(k) ? refm[k] : init_val(k);
   endfunction

   int ras_fall_cyc, ras_rise_cyc, cas_fall_cyc, cas_rise_cyc, addr_cyc, ras_falls;
   int viol_r10, viol_r12;
   logic prev_ras, prev_cas, prev_oe, prev_dqoe;
   logic [3:0] prev_dqout;
   logic [11:0] prev_addr, row_l, col_l;

   always @(negedge clk) begin
      if (!rst_n) begin
         ras_fall_cyc = 0; ras_rise_cyc = 0; cas_fall_cyc = 0; cas_rise_cyc = 1000;
         addr_cyc = 0; ras_falls = 0; viol_r10 = 0; viol_r12 = 0;
         prev_ras = 1'b1; prev_cas = 1'b1; prev_oe = 1'b1; prev_dqoe = 1'b0;
         prev_dqout = '0; prev_addr = '0; row_l = '0; col_l = '0;
         dram_dq_in = '0;
      end else begin
         ras_fall_cyc++; ras_rise_cyc++; cas_fall_cyc++; cas_rise_cyc++;
         if (dram_addr != prev_addr) addr_cyc = 0; else addr_cyc++;
         if (prev_ras && !dram_ras_n) begin
            check(ras_rise_cyc >= N_RP, "R5", "row precharge clocks", ras_rise_cyc, N_RP);
            ras_fall_cyc = 0; row_l = dram_addr; ras_falls++;
         end
         if (!prev_ras && dram_ras_n) begin
            check(ras_fall_cyc >= N_RAS, "R4", "row active clocks", ras_fall_cyc, N_RAS);
            ras_rise_cyc = 0;
         end
         if (prev_cas && !dram_cas_n) begin
            check(cas_rise_cyc >= N_CP, "R5", "column precharge clocks", cas_rise_cyc, N_CP);
            cas_fall_cyc = 0; col_l = dram_addr;
            if (!dram_we_n) begin
               check(prev_dqoe && dram_dq_oe && (prev_dqout == dram_dq_out), "R3",
                     "write data set up before column strobe", int'(prev_dqoe), 1);
               mdl[{row_l, dram_addr}] = dram_dq_out;
            end
         end
         if (!prev_cas && dram_cas_n) cas_rise_cyc = 0;
         if (!dram_cas_n && dram_ras_n) begin
            viol_r12++; $display("FAIL R12 column strobe low with row high: actual=1 expected=0");
         end
         if ((!dram_oe_n && dram_dq_oe) || (prev_oe && !dram_oe_n && prev_dqoe)) begin
            viol_r10++; $display("FAIL R10 bus overlap at output enable: actual=1 expected=0");
         end
         if (rd_valid)
            check((ras_fall_cyc >= N_RAC) && (cas_fall_cyc >= N_CAC) && (addr_cyc >= N_AA),
                  "R6", "capture clocks after row strobe", ras_fall_cyc, N_RAC);
         if (!dram_ras_n && !dram_cas_n && !dram_oe_n) begin
            logic [3:0] v;
            v = mdl_rd({row_l, col_l});
            if ((ras_fall_cyc + 1 >= N_RAC) && (cas_fall_cyc + 1 >= N_CAC) && (addr_cyc + 1 >= N_AA))
               dram_dq_in = v;
            else
               dram_dq_in = ~v;
         end else begin
            dram_dq_in = '0;
         end
         prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_oe = dram_oe_n;
         prev_dqoe = dram_dq_oe; prev_dqout = dram_dq_out; prev_addr = dram_addr;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic xact(input bit we, input logic [23:0] a, input logic [3:0] d, input string tag);
      bit got = 1'b0;
      bit val = 1'b0;
      logic [3:0] rdat = '0;
      @(negedge clk);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      for (int n = 0; n < 300; n++) begin
         @(negedge clk);
         if (ack) begin got = 1'b1; val = rd_valid; rdat = rd_data; break; end
      end
      req = 1'b0;
      check(got, tag, "acknowledge", int'(got), 1);
      check(val == !we, "R2", "read-valid only for reads", int'(val), int'(!we));
      if (we) refm[a] = d;
      else check(rdat == ref_rd(a), tag, "read data (R1 mapping)", int'(rdat), int'(ref_rd(a)));
   endtask

   initial begin
      logic [11:0] rows [4];
      int f;
      bit seen;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11 reset state
      check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !ack && !rd_valid,
            "R11", "strobes idle in reset", int'(dram_ras_n), 1);
      @(negedge clk); rst_n = 1'b1;

      // R3 and R2 at address corners
      xact(1'b1, 24'hFFFFFF, 4'hA, "R3");
      xact(1'b0, 24'hFFFFFF, 4'h0, "R2");
      xact(1'b1, 24'h000000, 4'h5, "R3");
      xact(1'b0, 24'h000000, 4'h0, "R1");
      xact(1'b0, 24'h123456, 4'h0, "R1");

      // R7 page hits produce no new row strobe
      xact(1'b0, 24'h0AB000, 4'h0, "R8");
      f = ras_falls;
      xact(1'b1, 24'h0AB001, 4'h3, "R7");
      xact(1'b1, 24'h0ABFFF, 4'hC, "R7");
      xact(1'b0, 24'h0AB001, 4'h0, "R7");
      xact(1'b0, 24'h0ABFFF, 4'h0, "R7");
      check(ras_falls == f, "R7", "row strobe falls during hits", ras_falls - f, 0);

      // R8 row change: one new fall
      f = ras_falls;
      xact(1'b0, 24'h0AC001, 4'h0, "R8");
      check(ras_falls == f + 1, "R8", "row strobe falls on row change", ras_falls - f, 1);

      // R9 refresh grant closes the row and holds off a request
      @(negedge clk); ref_grant = 1'b1;
      repeat (15) @(negedge clk);
      check(dram_ras_n && dram_cas_n, "R9", "strobes high under grant", int'(dram_ras_n), 1);
      f = ras_falls;
      req = 1'b1; req_we = 1'b0; req_addr = 24'h0AC001;
      seen = 1'b0;
      for (int n = 0; n < 30; n++) begin @(negedge clk); if (ack) seen = 1'b1; end
      check(!seen && (ras_falls == f), "R9", "no service under grant", int'(seen), 0);
      ref_grant = 1'b0;
      seen = 1'b0;
      for (int n = 0; n < 100; n++) begin
         @(negedge clk);
         if (ack) begin
            seen = 1'b1;
            check(rd_data == ref_rd(24'h0AC001), "R9", "data after grant", int'(rd_data),
                  int'(ref_rd(24'h0AC001)));
            break;
         end
      end
      req = 1'b0;
      check(seen, "R9", "served after grant drops", int'(seen), 1);

      // random traffic over a small row pool
      for (int i = 0; i < 4; i++) rows[i] = 12'($urandom);
      for (int i = 0; i < 400; i++) begin
         logic [23:0] a;
         a = {rows[$urandom % 4], 12'($urandom)};
         if (($urandom % 3) == 0) a[11:0] = 12'($urandom % 4);
         xact(1'($urandom), a, 4'($urandom), "R2");
      end

      repeat (10) @(negedge clk);
      check(viol_r10 == 0, "R10", "bus overlap count", viol_r10, 0);
      check(viol_r12 == 0, "R12", "column-without-row count", viol_r12, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule